// File: doc/BRIEF.md
# Half-Duplex SPI Controller

This block is an SPI controller. It runs as either bus master or bus slave and supports three data-wire arrangements. The first is ordinary full-duplex operation on two data pins. The second is half-duplex operation over one shared data pin whose direction the host chooses. The third is single-pin unidirectional use, either transmit-only or receive-only. Words are 8 bits, sent most significant bit first, in clock mode 0: SCK idles low, data changes after a falling edge, and data is sampled on a rising edge.

The host talks to a data register made of two buffers. A write fills a transmit buffer, which is copied into the shift register when a word starts. A completed word is placed in a receive buffer, which a read returns. Two flags track the buffers: `tx_empty` and `rx_full`. Configuration arrives on plain level inputs: enable, master/slave role, shared-wire mode, shared-wire direction, receive-only, software select and the software select level. In receive-only master operation the block clocks words back to back without any write. Clearing enable stops it only after the word in progress has finished.

On the pin side the block drives SCK, MOSI and MISO, each with an output enable for an external tristate pad, and reads NSS. As a slave it passes SCK and NSS through two-flop synchronisers and detects their edges in the system clock domain.

Top module: `spi_hd_ctrl`

## Requirements
- R1: After reset, `sck_o` is 0, `busy` is 0, `tx_empty` is 1, `rx_full` is 0, and `mosi_oe` and `miso_oe` are both 0.
- R2: As an enabled master that is not in a receive-only arrangement, a host write starts a word. The word is shifted out on `mosi_o` MSB first, changing after each falling SCK edge. One SCK period lasts DIV system clocks, and SCK returns low when the master goes idle.
- R3: `busy` stays 1 for the whole of a master transfer. If the transmit buffer is refilled before a word ends, the next word follows with no idle gap and `busy` does not drop. `busy` is 0 once the master stops.
- R4: A host write clears `tx_empty`. `tx_empty` is set again when the buffer contents are copied into the shift register. `rx_full` is set when a word completes. `host_rdata` returns the received word, and a `host_rd` pulse clears `rx_full`.
- R5: With shared-wire mode off and receive-only off, a master drives `mosi_oe`=1 and `miso_oe`=0. It transmits on MOSI and receives on MISO at the same time (full-duplex, also used as transmit-only).
- R6: With shared-wire mode off and receive-only on, the transmit pin's output enable is 0: `mosi_oe` for a master, `miso_oe` for a slave.
- R7: An enabled master in a receive-only arrangement clocks without any host write. It receives words back to back and never consumes the transmit buffer, so `tx_empty` stays 1.
- R8: If enable is cleared while a receive-only master is mid-word, that word still completes and sets `rx_full`. Afterwards SCK stays low and `busy` is 0.
- R9: In shared-wire mode the data pin is MOSI for a master and MISO for a slave. That pin's output enable equals the direction bit (1 = drive). With direction 0 the block receives from that same pin, and a master then clocks on its own as in R7.
- R10: A slave is selected while `nss_i` is low. While selected it samples its receive pin on SCK rising edges and shifts the transmit buffer out on `miso_o` MSB first. `miso_oe` is 1 only while it is selected. When not selected it receives nothing.
- R11: With software select on, selection follows the inverse of `cfg_ssi` and `nss_i` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_enable | input | 1 | Block enable |
| cfg_master | input | 1 | 1 = master, 0 = slave |
| cfg_bidir | input | 1 | Shared single data wire mode |
| cfg_bidir_out | input | 1 | Shared wire direction, 1 = drive |
| cfg_rxonly | input | 1 | Receive-only when shared-wire mode is off |
| cfg_soft_nss | input | 1 | Use `cfg_ssi` instead of `nss_i` for selection |
| cfg_ssi | input | 1 | Software select level (0 = selected) |
| host_wr | input | 1 | Data register write strobe |
| host_rd | input | 1 | Data register read strobe |
| host_wdata | input | DW | Write data for transmit buffer |
| host_rdata | output | DW | Receive buffer contents |
| tx_empty | output | 1 | Transmit buffer empty |
| rx_full | output | 1 | Receive buffer holds an unread word |
| busy | output | 1 | Transfer in progress |
| sck_o | output | 1 | Master serial clock out |
| sck_oe | output | 1 | Serial clock output enable |
| sck_i | input | 1 | Slave serial clock in |
| nss_i | input | 1 | Slave select, active low |
| mosi_o | output | 1 | MOSI output value |
| mosi_oe | output | 1 | MOSI output enable |
| mosi_i | input | 1 | MOSI input value |
| miso_o | output | 1 | MISO output value |
| miso_oe | output | 1 | MISO output enable |
| miso_i | input | 1 | MISO input value |

## Verification
The embedded properties assume that the role, wire-mode and direction inputs change only while the block is disabled and idle. The bench always drops enable and waits for `busy` to fall before it reconfigures. As a slave, the block assumes SCK is low when selection begins and that the external SCK half period and data hold time exceed the synchroniser latency of about three system clocks. The bench therefore holds each slave SCK level and data bit for eight clocks. On the master side, the bench's slave model changes its output only after it sees a falling SCK edge, which leaves the data stable for a full half period before the sampling edge.

// File: rtl/spi_hd_pkg.sv
package spi_hd_pkg;

  typedef struct packed {
    logic en;
    logic master;
    logic bidir;
    logic bidir_out;
    logic rxonly;
    logic soft_nss;
    logic ssi;
  } spi_cfg_t;

  // Receive-only arrangement: shared wire pointed inward, or receive-only on a split wire.
  function automatic logic rx_only_mode(spi_cfg_t c);
    return c.bidir ? !c.bidir_out : c.rxonly;
  endfunction

  // Whether the transmit-side data pin may be driven under this configuration.
  function automatic logic tx_pin_drive(spi_cfg_t c);
    return c.bidir ? c.bidir_out : !c.rxonly;
  endfunction

  // SCK half period in system clocks for an even divisor.
  function automatic int unsigned half_div(int unsigned div);
    return (div < 2) ? 1 : div / 2;
  endfunction

endpackage

// File: rtl/spi_hd_sync.sv
module spi_hd_sync #(
  parameter int unsigned STAGES = 2,
  parameter logic        INIT   = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] ff;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ff <= {STAGES{INIT}};
    else        ff <= {ff[STAGES-2:0], d};
  end

  assign q = ff[STAGES-1];
endmodule

// File: rtl/spi_hd_mseq.sv
module spi_hd_mseq #(
  parameter int unsigned DIV  = 8,
  parameter int unsigned BITS = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic cont,
  output logic sck,
  output logic rise_evt,
  output logic fall_evt,
  output logic word_done,
  output logic active
);
  localparam int unsigned HALF = spi_hd_pkg::half_div(DIV);
  localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;
  localparam int BW = (BITS > 1) ? $clog2(BITS) : 1;

  logic [CW-1:0] div_cnt;
  logic [BW-1:0] bit_cnt;
  logic          tick;

  assign tick      = active && (div_cnt == CW'(HALF - 1));
  assign rise_evt  = tick && !sck;
  assign fall_evt  = tick && sck;
  assign word_done = fall_evt && (bit_cnt == BW'(BITS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active  <= 1'b0;
      sck     <= 1'b0;
      div_cnt <= '0;
      bit_cnt <= '0;
    end else if (!active) begin
      if (start) begin
        active  <= 1'b1;
        sck     <= 1'b0;
        div_cnt <= '0;
        bit_cnt <= '0;
      end
    end else begin
      div_cnt <= tick ? '0 : div_cnt + 1'b1;
      if (tick) sck <= ~sck;
      if (fall_evt) bit_cnt <= word_done ? '0 : bit_cnt + 1'b1;
      if (word_done && !cont) active <= 1'b0;
    end
  end

  // R2: SCK only moves on a divider tick
  p_sck_only_on_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(sck));
  // R8: an idle sequencer holds SCK low
  p_idle_sck_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> !sck);
  // R3: sequencer stays active into the next word when continuation is requested
  p_cont_keeps_active_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (word_done && cont) |=> active);
endmodule

// File: rtl/spi_hd_ctrl.sv
module spi_hd_ctrl
  import spi_hd_pkg::*;
#(
  parameter int unsigned DW  = 8,
  parameter int unsigned DIV = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_enable,
  input  logic          cfg_master,
  input  logic          cfg_bidir,
  input  logic          cfg_bidir_out,
  input  logic          cfg_rxonly,
  input  logic          cfg_soft_nss,
  input  logic          cfg_ssi,
  input  logic          host_wr,
  input  logic          host_rd,
  input  logic [DW-1:0] host_wdata,
  output logic [DW-1:0] host_rdata,
  output logic          tx_empty,
  output logic          rx_full,
  output logic          busy,
  output logic          sck_o,
  output logic          sck_oe,
  input  logic          sck_i,
  input  logic          nss_i,
  output logic          mosi_o,
  output logic          mosi_oe,
  input  logic          mosi_i,
  output logic          miso_o,
  output logic          miso_oe,
  input  logic          miso_i
);
  localparam int CW = (DW > 1) ? $clog2(DW) : 1;

  spi_cfg_t cfg;
  assign cfg = '{en: cfg_enable, master: cfg_master, bidir: cfg_bidir,
                 bidir_out: cfg_bidir_out, rxonly: cfg_rxonly,
                 soft_nss: cfg_soft_nss, ssi: cfg_ssi};

  logic rxo, drive;
  assign rxo   = rx_only_mode(cfg);
  assign drive = tx_pin_drive(cfg);

  // ---------------- master sequencing ----------------
  logic m_go, m_active, m_sck, m_rise, m_fall, m_done;
  assign m_go = cfg.en && cfg.master && (rxo || !tx_empty);

  spi_hd_mseq #(.DIV(DIV), .BITS(DW)) u_mseq (
    .clk(clk), .rst_n(rst_n), .start(m_go), .cont(m_go),
    .sck(m_sck), .rise_evt(m_rise), .fall_evt(m_fall),
    .word_done(m_done), .active(m_active));

  // ---------------- slave sequencing ----------------
  logic sck_q, sck_qd, nss_q;
  spi_hd_sync #(.STAGES(2), .INIT(1'b0)) u_sck_sync (
    .clk(clk), .rst_n(rst_n), .d(sck_i), .q(sck_q));
  spi_hd_sync #(.STAGES(2), .INIT(1'b1)) u_nss_sync (
    .clk(clk), .rst_n(rst_n), .d(nss_i), .q(nss_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sck_qd <= 1'b0;
    else        sck_qd <= sck_q;
  end

  logic          sel, s_rise, s_fall, s_done, s_load, s_loaded, s_busy;
  logic [CW-1:0] s_cnt;

  assign sel    = cfg.en && !cfg.master && (cfg.soft_nss ? !cfg.ssi : !nss_q);
  assign s_rise = sel && sck_q && !sck_qd;
  assign s_fall = sel && s_busy && !sck_q && sck_qd;
  assign s_done = s_fall && (s_cnt == CW'(DW - 1));
  assign s_load = sel && !s_loaded && !s_busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_cnt    <= '0;
      s_loaded <= 1'b0;
      s_busy   <= 1'b0;
    end else if (!sel) begin
      s_cnt    <= '0;
      s_loaded <= 1'b0;
      s_busy   <= 1'b0;
    end else begin
      if (s_load) s_loaded <= 1'b1;
      if (s_rise) s_busy <= 1'b1;
      if (s_fall) s_cnt <= s_cnt + 1'b1;
      if (s_done) begin
        s_cnt    <= '0;
        s_loaded <= 1'b0;
        s_busy   <= 1'b0;
      end
    end
  end

  // ---------------- shared datapath ----------------
  logic ev_load, ev_rise, ev_fall, ev_done, take, din;
  assign ev_load = cfg.master ? (m_go && (!m_active || m_done)) : s_load;
  assign ev_rise = cfg.master ? m_rise : s_rise;
  assign ev_fall = cfg.master ? m_fall : s_fall;
  assign ev_done = cfg.master ? m_done : s_done;
  assign take    = ev_load && !rxo && !tx_empty;
  assign din     = cfg.master ? (cfg.bidir ? mosi_i : miso_i)
                              : (cfg.bidir ? miso_i : mosi_i);

  logic [DW-1:0] shreg, txbuf, rxbuf;
  logic          rx_bit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg    <= '0;
      txbuf    <= '0;
      rxbuf    <= '0;
      rx_bit   <= 1'b0;
      tx_empty <= 1'b1;
      rx_full  <= 1'b0;
    end else begin
      if (ev_load)      shreg <= take ? txbuf : '0;
      else if (ev_fall) shreg <= {shreg[DW-2:0], rx_bit};
      if (ev_rise) rx_bit <= din;
      if (ev_done) rxbuf <= {shreg[DW-2:0], rx_bit};
      if (host_wr) txbuf <= host_wdata;
      if (host_wr)   tx_empty <= 1'b0;
      else if (take) tx_empty <= 1'b1;
      if (ev_done)      rx_full <= 1'b1;
      else if (host_rd) rx_full <= 1'b0;
    end
  end

  assign host_rdata = rxbuf;
  assign busy       = cfg.master ? m_active : s_busy;
  assign sck_o      = m_sck;
  assign sck_oe     = cfg.master && (cfg.en || m_active);
  assign mosi_o     = shreg[DW-1];
  assign miso_o     = shreg[DW-1];
  assign mosi_oe    = cfg.master && (cfg.en || m_active) && drive;
  assign miso_oe    = sel && drive;

  // R4: a host write leaves the transmit buffer marked full
  p_wr_clears_empty_r4: assert property (@(posedge clk) disable iff (!rst_n)
    host_wr |=> !tx_empty);
  // R4: a completed word always raises the receive flag
  p_done_sets_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_done |=> rx_full);
  // R7: receive-only arrangements never consume the transmit buffer
  p_rxonly_keeps_tx_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rxo && !host_wr) |=> $stable(tx_empty));
  // R3: a toggling master clock implies a transfer in progress
  p_sck_implies_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sck_o |-> busy);
  // R10: a slave never finishes a word without first being selected
  p_slave_done_selected_r10: assert property (@(posedge clk) disable iff (!rst_n)
    s_done |-> $past(sel));
endmodule

// File: tb/sim_spi_hd_ctrl.sv
module sim_spi_hd_ctrl;
  localparam int DIV = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic cfg_enable = 0, cfg_master = 0, cfg_bidir = 0, cfg_bidir_out = 0;
  logic cfg_rxonly = 0, cfg_soft_nss = 0, cfg_ssi = 0;
  logic host_wr = 0, host_rd = 0;
  logic [7:0] host_wdata = '0, host_rdata;
  logic tx_empty, rx_full, busy, sck_o, sck_oe, mosi_o, mosi_oe, miso_o, miso_oe;
  logic t_sck = 0, t_nss = 1, t_mosi = 0, t_miso = 0, slv_mode = 0;
  logic m_out = 0, drive_mosi = 0;
  logic mosi_i, miso_i;

  assign mosi_i = slv_mode ? t_mosi : (drive_mosi ? m_out : ~m_out);
  assign miso_i = slv_mode ? t_miso : (drive_mosi ? ~m_out : m_out);

  spi_hd_ctrl #(.DW(8), .DIV(DIV)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_master(cfg_master),
    .cfg_bidir(cfg_bidir), .cfg_bidir_out(cfg_bidir_out), .cfg_rxonly(cfg_rxonly),
    .cfg_soft_nss(cfg_soft_nss), .cfg_ssi(cfg_ssi), .host_wr(host_wr),
    .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .tx_empty(tx_empty), .rx_full(rx_full), .busy(busy), .sck_o(sck_o),
    .sck_oe(sck_oe), .sck_i(t_sck), .nss_i(t_nss), .mosi_o(mosi_o),
    .mosi_oe(mosi_oe), .mosi_i(mosi_i), .miso_o(miso_o), .miso_oe(miso_oe),
    .miso_i(miso_i));

  int n_chk = 0, n_fail = 0;
  string cur_req = "R4";

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  logic [7:0] exp_mo[$], exp_rx[$], slv_q[$];
  bit chk_mo = 0, chk_rx = 0, period_done = 0;
  int mo_count = 0, rx_count = 0, m_idx = 0;
  logic [7:0] m_cur = '0, m_cap = '0;
  logic m_prev = 0;
  longint cyc = 0, last_rise = 0;

  always @(posedge clk) cyc++;

  function automatic void take_next();
    m_cur = (slv_q.size() != 0) ? slv_q.pop_front() : 8'h00;
    exp_rx.push_back(m_cur);
    m_out = m_cur[7];
  endfunction

  task automatic arm();
    m_idx = 0;
    take_next();
  endtask

  // Bench slave model facing the master-mode DUT
  always @(negedge clk) begin
    if (rst_n && cfg_master) begin
      if (sck_o && !m_prev) begin
        m_cap = {m_cap[6:0], mosi_o};
        if (m_idx > 0 && !period_done) begin
          chk(cyc - last_rise == DIV, "R2 sck period", int'(cyc - last_rise), DIV);
          period_done = 1;
        end
        last_rise = cyc;
      end
      if (!sck_o && m_prev) begin
        m_idx++;
        if (m_idx == 8) begin
          m_idx = 0;
          mo_count++;
          if (chk_mo) begin
            if (exp_mo.size() == 0) chk(0, "R2 unexpected word", m_cap, 0);
            else begin
              logic [7:0] e;
              e = exp_mo.pop_front();
              chk(m_cap == e, "R2 mosi word", m_cap, e);
            end
          end
          take_next();
        end else m_out = m_cur[7 - m_idx];
      end
      m_prev = sck_o;
    end
  end

  // Scoreboard monitor for the receive buffer
  always @(negedge clk) begin
    host_rd <= 1'b0;
    if (rst_n && rx_full && !host_rd) begin
      rx_count++;
      if (chk_rx) begin
        if (exp_rx.size() == 0) chk(0, {cur_req, " unexpected rx"}, host_rdata, 0);
        else begin
          logic [7:0] e;
          e = exp_rx.pop_front();
          chk(host_rdata == e, {cur_req, " rx word"}, host_rdata, e);
        end
      end
      host_rd <= 1'b1;
    end
  end

  task automatic wr(input logic [7:0] d);
    @(negedge clk);
    host_wr = 1; host_wdata = d;
    exp_mo.push_back(d);
    @(negedge clk);
    host_wr = 0;
  endtask

  task automatic wait_mo(input int n);
    for (int t = 0; t < 3000 && mo_count < n; t++) @(negedge clk);
  endtask

  task automatic wait_rx(input int n);
    for (int t = 0; t < 3000 && rx_count < n; t++) @(negedge clk);
  endtask

  task automatic flush();
    exp_mo.delete(); exp_rx.delete(); slv_q.delete();
    mo_count = 0; rx_count = 0; period_done = 0;
  endtask

  task automatic slv_word(input logic [7:0] s, input bit on_miso, output logic [7:0] g);
    for (int i = 7; i >= 0; i--) begin
      t_mosi = on_miso ? ~s[i] : s[i];
      t_miso = on_miso ? s[i] : ~s[i];
      repeat (8) @(negedge clk);
      t_sck = 1;
      repeat (8) @(negedge clk);
      g[i] = miso_o;
      t_sck = 0;
    end
    repeat (8) @(negedge clk);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    summary();
    $finish;
  end

  initial begin
    logic [7:0] got;
    int lows;
    repeat (5) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(sck_o == 0, "R1 sck", sck_o, 0);
    chk(busy == 0, "R1 busy", busy, 0);
    chk(tx_empty == 1, "R1 tx_empty", tx_empty, 1);
    chk(rx_full == 0, "R1 rx_full", rx_full, 0);
    chk(mosi_oe == 0 && miso_oe == 0, "R1 oe", {mosi_oe, miso_oe}, 0);

    // Master full-duplex with back-to-back words
    cfg_master = 1; cfg_enable = 1; cur_req = "R5"; chk_rx = 1; chk_mo = 1;
    slv_q.push_back(8'h3C); slv_q.push_back(8'h96); arm();
    @(negedge clk);
    chk(mosi_oe == 1 && miso_oe == 0, "R5 oe", {mosi_oe, miso_oe}, 2);
    wr(8'hA5);
    chk(tx_empty == 0, "R4 write clears tx_empty", tx_empty, 0);
    @(negedge clk);
    chk(busy == 1, "R3 busy at start", busy, 1);
    chk(tx_empty == 1, "R4 tx_empty on load", tx_empty, 1);
    wr(8'h5A);
    lows = 0;
    for (int i = 0; i < 100; i++) begin @(negedge clk); if (!busy) lows++; end
    chk(lows == 0, "R3 busy gap", lows, 0);
    wait_mo(2); wait_rx(2);
    repeat (5) @(negedge clk);
    chk(mo_count == 2, "R2 word count", mo_count, 2);
    chk(busy == 0 && sck_o == 0, "R3 idle", {busy, sck_o}, 0);
    chk(rx_full == 0, "R4 read clears rx_full", rx_full, 0);
    cfg_enable = 0; flush(); chk_mo = 0;

    // Master receive-only, stop on disable
    cfg_rxonly = 1; cur_req = "R7";
    slv_q.push_back(8'h11); slv_q.push_back(8'h22); slv_q.push_back(8'hE3); slv_q.push_back(8'h44);
    arm();
    cfg_enable = 1;
    repeat (2) @(negedge clk);
    chk(busy == 1, "R7 clocks without write", busy, 1);
    chk(mosi_oe == 0, "R6 master tx pin off", mosi_oe, 0);
    wait_rx(2);
    repeat (10) @(negedge clk);
    cfg_enable = 0;
    repeat (150) @(negedge clk);
    chk(rx_count == 3, "R8 word finished", rx_count, 3);
    chk(busy == 0 && sck_o == 0, "R8 stopped", {busy, sck_o}, 0);
    chk(tx_empty == 1, "R7 tx untouched", tx_empty, 1);
    flush();

    // Master shared wire, inward then outward
    cfg_rxonly = 0; cfg_bidir = 1; cfg_bidir_out = 0; drive_mosi = 1; cur_req = "R9";
    slv_q.push_back(8'hC7); slv_q.push_back(8'h5E); arm();
    cfg_enable = 1;
    @(negedge clk);
    chk(mosi_oe == 0, "R9 shared pin released", mosi_oe, 0);
    wait_rx(1);
    cfg_enable = 0;
    repeat (150) @(negedge clk);
    chk(rx_count == 2, "R9 rx words", rx_count, 2);
    flush();
    cfg_bidir_out = 1; drive_mosi = 0; chk_rx = 0; chk_mo = 1; arm();
    cfg_enable = 1;
    @(negedge clk);
    chk(mosi_oe == 1, "R9 shared pin driven", mosi_oe, 1);
    wr(8'h69);
    wait_mo(1);
    chk(mo_count == 1, "R9 tx word", mo_count, 1);
    cfg_enable = 0; chk_mo = 0;
    repeat (20) @(negedge clk);
    flush();

    // Slave full-duplex
    cfg_master = 0; cfg_bidir = 0; cfg_bidir_out = 0; slv_mode = 1; chk_rx = 1;
    cur_req = "R10"; cfg_enable = 1;
    wr(8'hB4);
    chk(miso_oe == 0, "R10 unselected oe", miso_oe, 0);
    exp_rx.push_back(8'h4D);
    t_nss = 0; repeat (8) @(negedge clk);
    chk(miso_oe == 1, "R10 selected oe", miso_oe, 1);
    slv_word(8'h4D, 0, got);
    chk(got == 8'hB4, "R10 miso word", got, 8'hB4);
    t_nss = 1; repeat (8) @(negedge clk);
    chk(rx_count == 1, "R10 rx count", rx_count, 1);
    slv_word(8'h0F, 0, got);
    chk(rx_count == 1 && rx_full == 0, "R10 unselected no rx", rx_count, 1);

    // Slave receive-only
    cfg_enable = 0; cfg_rxonly = 1; cfg_enable = 1; cur_req = "R6";
    exp_rx.push_back(8'h3A);
    t_nss = 0; repeat (8) @(negedge clk);
    chk(miso_oe == 0, "R6 slave tx pin off", miso_oe, 0);
    slv_word(8'h3A, 0, got);
    t_nss = 1; repeat (8) @(negedge clk);
    chk(rx_count == 2, "R6 slave rx count", rx_count, 2);

    // Slave shared wire
    cfg_enable = 0; cfg_rxonly = 0; cfg_bidir = 1; cfg_bidir_out = 1; cfg_enable = 1;
    cur_req = "R9"; chk_rx = 0;
    wr(8'hE1);
    t_nss = 0; repeat (8) @(negedge clk);
    chk(miso_oe == 1, "R9 slave drives miso", miso_oe, 1);
    slv_word(8'h00, 0, got);
    chk(got == 8'hE1, "R9 slave tx word", got, 8'hE1);
    t_nss = 1; repeat (8) @(negedge clk);
    cfg_enable = 0; cfg_bidir_out = 0; cfg_enable = 1; chk_rx = 1;
    exp_rx.push_back(8'h72);
    t_nss = 0; repeat (8) @(negedge clk);
    chk(miso_oe == 0, "R9 slave releases miso", miso_oe, 0);
    slv_word(8'h72, 1, got);
    t_nss = 1; repeat (8) @(negedge clk);

    // Software select
    cfg_enable = 0; cfg_bidir = 0; cfg_soft_nss = 1; cfg_ssi = 1; cfg_enable = 1;
    cur_req = "R11"; rx_count = 0;
    t_nss = 0; repeat (8) @(negedge clk);
    slv_word(8'h99, 0, got);
    chk(rx_count == 0 && rx_full == 0, "R11 ssi high ignores nss", rx_count, 0);
    t_nss = 1; cfg_ssi = 0;
    exp_rx.push_back(8'h2B);
    repeat (8) @(negedge clk);
    slv_word(8'h2B, 0, got);
    repeat (8) @(negedge clk);
    chk(rx_count == 1, "R11 ssi low selects", rx_count, 1);

    summary();
    $finish;
  end
endmodule